// File: doc/BRIEF.md
# MMU Command Decoder and Register Mover

This block sits beside a processor's instruction decoder. It receives a coprocessor-class operation word together with the 16-bit extension word that follows it, and sorts the pair into MMU command classes. For the register-move class it carries out the whole operation itself. The caller supplies a base address. The block then moves the selected MMU register to or from memory, one 16-bit halfword at a time, over a narrow request/acknowledge port.

The block holds four MMU registers:

- a 32-bit translation control word;
- two 64-bit root pointers, one for supervisor space and one for CPU space, each a limit word followed by a table-pointer word;
- a 16-bit MMU status word.

All other command classes are only reported to the caller through a class code. Their side effects happen elsewhere. Bit 31 of the translation control word drives the translation-enable output.

A command is accepted only while the block is idle. The class code is shown one cycle after acceptance. A register move signals completion with a one-cycle done pulse, and an unsupported register move signals a one-cycle error pulse instead.

Top module: `mmu_cmd_port`

## Requirements
- R1: The operation word is classified as follows, and its extension word is then ignored:
  - decrement-and-branch (code 9) when (op & 0xFFF8) == 0xF048; this is tested first;
  - conditional-set (6) when (op & 0xFFC0) == 0xF040;
  - 16-bit branch (7) when (op & 0xFFC0) == 0xF080;
  - 32-bit branch (8) when (op & 0xFFC0) == 0xF0C0;
  - not-MMU (0) for anything outside these groups and the general group.
- R2: In the general group ((op & 0xFFC0) == 0xF000) the extension word is tested in this priority order:
  - load-entry (code 2): (ext & 0xFDE0) == 0x2000;
  - flush (3): (ext & 0xE200) == 0x2000; this also catches 0x2800 and 0x2C0x;
  - flush-root (4): ext == 0xA000;
  - probe (5): (ext & 0xE000) == 0x8000;
  - register move (1): everything else.
- R3: For every accepted command, cls_o holds the class code and cls_vld_o pulses high for the one cycle after the accepting clock edge.
- R4: In a register move, ext[9] = 1 copies the register to memory (mem_we_o = 1). A 32-bit translation control value is written as the upper halfword at base, then the lower halfword at base+2.
- R5: A root pointer moves as four halfwords at base+0, +2, +4, +6, in this order: limit upper, limit lower, pointer upper, pointer lower. A load changes the register only once all four halfwords have arrived.
- R6: Form 3 (ext[15:13] = 3) moves the 16-bit status word as one halfword at base.
- R7: Forms 0 and 2 address the same register set. ext[12:10] selects the register: 0 is translation control, 2 is the supervisor root and 3 is the CPU root.
- R8: ext[9] = 0 loads the register from memory (mem_we_o = 0). Loading one register leaves the others unchanged.
- R9: xlate_en_o equals bit 31 of the translation control word. It changes only in the cycle where done_o is high after a translation control load.
- R10: mem_req_o, mem_addr_o and mem_we_o hold steady until mem_ack_i is sampled high. Only then does the block step to the next halfword.
- R11: done_o is a one-cycle pulse in the cycle after the clock edge that sampled the last acknowledge.
- R12: A register move with an unsupported form (1, 4 to 7 after R2) or register code (1, 4 to 7) gives class 1 with a one-cycle err_o pulse. It makes no memory transfer and changes no register.
- R13: After reset all registers are zero, and busy_o, mem_req_o, cls_vld_o, err_o, done_o and xlate_en_o are all low.
- R14: While busy_o is high, cmd_valid_i is ignored: there is no class pulse, no error, and the running transfer is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present; accepted when not busy |
| cmd_opword_i | input | 16 | Coprocessor operation word |
| cmd_ext_i | input | 16 | Extension word |
| cmd_base_i | input | AW | Base address for a register move |
| busy_o | output | 1 | Register move in progress |
| cls_vld_o | output | 1 | One-cycle pulse: cls_o is updated |
| cls_o | output | 4 | Command class code |
| err_o | output | 1 | One-cycle pulse: unsupported register move |
| done_o | output | 1 | One-cycle pulse: register move finished |
| xlate_en_o | output | 1 | Translation enable (control bit 31) |
| mem_req_o | output | 1 | Halfword transfer request |
| mem_we_o | output | 1 | 1 = write to memory, 0 = read |
| mem_addr_o | output | AW | Halfword byte address |
| mem_wdata_o | output | HW | Write data |
| mem_rdata_i | input | HW | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Transfer acknowledge |

## Verification
The bench builds the block with its defaults: a 32-bit address, 16-bit halfwords, a 32-bit control word, 64-bit root pointers and a 16-bit status word. With these values, every halfword count (one, two and four) and the full shift buffer are exercised. The memory model's acknowledge latency is varied between zero and three cycles. This reaches back-to-back halfword steps as well as long waits in which the request must hold. The long waits also leave room to present a second command in the middle of a transfer.

// File: rtl/mmu_cmd_pkg.sv
package mmu_cmd_pkg;
   localparam int CODE_W = 16;

   typedef enum logic [3:0] {
      CLS_NONE       = 4'd0,
      CLS_REG_MOVE   = 4'd1,
      CLS_LOAD_ENTRY = 4'd2,
      CLS_FLUSH      = 4'd3,
      CLS_FLUSH_ROOT = 4'd4,
      CLS_PROBE      = 4'd5,
      CLS_COND_SET   = 4'd6,
      CLS_BRANCH16   = 4'd7,
      CLS_BRANCH32   = 4'd8,
      CLS_DEC_BRANCH = 4'd9
   } cmd_cls_e;

   typedef enum logic [1:0] {
      TGT_CTRL     = 2'd0,
      TGT_SUP_ROOT = 2'd1,
      TGT_CPU_ROOT = 2'd2,
      TGT_STATUS   = 2'd3
   } mmu_tgt_e;

   typedef struct packed {
      cmd_cls_e cls;
      logic     move_ok;
      logic     move_bad;
      logic     to_mem;
      mmu_tgt_e tgt;
   } cmd_dec_t;
endpackage

// File: rtl/mmu_cmd_classify.sv
module mmu_cmd_classify
   import mmu_cmd_pkg::*;
(
   input  logic [CODE_W-1:0] opword_i,
   input  logic [CODE_W-1:0] ext_i,
   output cmd_dec_t          dec_o
);
   always_comb begin
      dec_o = '{cls: CLS_NONE, move_ok: 1'b0, move_bad: 1'b0,
                to_mem: 1'b0, tgt: TGT_CTRL};
      if ((opword_i & 16'hFFF8) == 16'hF048) begin
         dec_o.cls = CLS_DEC_BRANCH;
      end else if ((opword_i & 16'hFFC0) == 16'hF040) begin
         dec_o.cls = CLS_COND_SET;
      end else if ((opword_i & 16'hFFC0) == 16'hF080) begin
         dec_o.cls = CLS_BRANCH16;
      end else if ((opword_i & 16'hFFC0) == 16'hF0C0) begin
         dec_o.cls = CLS_BRANCH32;
      end else if ((opword_i & 16'hFFC0) == 16'hF000) begin
         if ((ext_i & 16'hFDE0) == 16'h2000) begin
            dec_o.cls = CLS_LOAD_ENTRY;
         end else if ((ext_i & 16'hE200) == 16'h2000) begin
            dec_o.cls = CLS_FLUSH;
         end else if (ext_i == 16'hA000) begin
            dec_o.cls = CLS_FLUSH_ROOT;
         end else if ((ext_i & 16'hE000) == 16'h8000) begin
            dec_o.cls = CLS_PROBE;
         end else begin
            dec_o.cls    = CLS_REG_MOVE;
            dec_o.to_mem = ext_i[9];
            case (ext_i[15:13])
               3'd0, 3'd2: begin
                  case (ext_i[12:10])
                     3'd0:    begin dec_o.move_ok = 1'b1; dec_o.tgt = TGT_CTRL;     end
                     3'd2:    begin dec_o.move_ok = 1'b1; dec_o.tgt = TGT_SUP_ROOT; end
                     3'd3:    begin dec_o.move_ok = 1'b1; dec_o.tgt = TGT_CPU_ROOT; end
                     default: dec_o.move_bad = 1'b1;
                  endcase
               end
               3'd3: begin
                  dec_o.move_ok = 1'b1;
                  dec_o.tgt     = TGT_STATUS;
               end
               default: dec_o.move_bad = 1'b1;
            endcase
         end
      end
   end

   always_comb begin
      assert (!(dec_o.move_ok && dec_o.move_bad))
         else $error("a_r12_ok_bad_exclusive: move both good and bad");
   end
endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
   import mmu_cmd_pkg::*;
#(
   parameter int TC_W = 32,
   parameter int RP_W = 64,
   parameter int SR_W = 16
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  mmu_tgt_e        rd_tgt_i,
   output logic [RP_W-1:0] rd_val_o,
   input  logic            commit_i,
   input  mmu_tgt_e        wr_tgt_i,
   input  logic [RP_W-1:0] wr_val_i,
   output logic            xlate_en_o
);
   localparam int N_ROOT = 2;

   logic [TC_W-1:0] tc_q;
   logic [SR_W-1:0] sr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tc_q <= '0;
         sr_q <= '0;
      end else if (commit_i) begin
         if (wr_tgt_i == TGT_CTRL)   tc_q <= wr_val_i[TC_W-1:0];
         if (wr_tgt_i == TGT_STATUS) sr_q <= wr_val_i[SR_W-1:0];
      end
   end

   for (genvar g = 0; g < N_ROOT; g++) begin : g_root
      localparam mmu_tgt_e SLOT_TGT = (g == 0) ? TGT_SUP_ROOT : TGT_CPU_ROOT;
      logic [RP_W-1:0] val_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                val_q <= '0;
         else if (commit_i && wr_tgt_i == SLOT_TGT)  val_q <= wr_val_i;
      end
   end

   always_comb begin
      case (rd_tgt_i)
         TGT_CTRL:     rd_val_o = RP_W'(tc_q) << (RP_W - TC_W);
         TGT_SUP_ROOT: rd_val_o = g_root[0].val_q;
         TGT_CPU_ROOT: rd_val_o = g_root[1].val_q;
         default:      rd_val_o = RP_W'(sr_q) << (RP_W - SR_W);
      endcase
   end

   assign xlate_en_o = tc_q[TC_W-1];

   a_r9_xlate_from_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && wr_tgt_i == TGT_CTRL) |=> (xlate_en_o == $past(wr_val_i[TC_W-1])));
endmodule

// File: rtl/mmu_xfer_seq.sv
module mmu_xfer_seq #(
   parameter int AW    = 32,
   parameter int HW    = 16,
   parameter int BUF_W = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             to_mem_i,
   input  logic [$clog2(BUF_W/HW+1)-1:0] nhw_i,
   input  logic [AW-1:0]    base_i,
   input  logic [BUF_W-1:0] snap_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             commit_o,
   output logic [BUF_W-1:0] commit_val_o,
   output logic             mem_req_o,
   output logic             mem_we_o,
   output logic [AW-1:0]    mem_addr_o,
   output logic [HW-1:0]    mem_wdata_o,
   input  logic [HW-1:0]    mem_rdata_i,
   input  logic             mem_ack_i
);
   localparam int SLOTS = BUF_W / HW;
   localparam int CW    = $clog2(SLOTS + 1);
   localparam int STEP  = HW / 8;

   typedef enum logic {SQ_IDLE, SQ_XFER} sq_e;

   sq_e              st_q;
   logic [CW-1:0]    idx_q, cnt_q;
   logic [AW-1:0]    base_q;
   logic             dir_q;
   logic [BUF_W-1:0] buf_q;
   logic             done_q;
   logic             last;

   assign last = (idx_q == cnt_q - CW'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= SQ_IDLE;
         idx_q  <= '0;
         cnt_q  <= '0;
         base_q <= '0;
         dir_q  <= 1'b0;
         buf_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (start_i) begin
                  st_q   <= SQ_XFER;
                  idx_q  <= '0;
                  cnt_q  <= nhw_i;
                  base_q <= base_i;
                  dir_q  <= to_mem_i;
                  buf_q  <= snap_i;
               end
            end
            default: begin
               if (mem_ack_i) begin
                  if (dir_q) buf_q <= buf_q << HW;
                  else       buf_q <= {buf_q[BUF_W-HW-1:0], mem_rdata_i};
                  idx_q <= idx_q + CW'(1);
                  if (last) begin
                     st_q   <= SQ_IDLE;
                     done_q <= 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign busy_o       = (st_q != SQ_IDLE);
   assign done_o       = done_q;
   assign mem_req_o    = (st_q == SQ_XFER);
   assign mem_we_o     = dir_q;
   assign mem_addr_o   = base_q + AW'(idx_q) * AW'(STEP);
   assign mem_wdata_o  = buf_q[BUF_W-1 -: HW];
   assign commit_o     = (st_q == SQ_XFER) && mem_ack_i && last && !dir_q;
   assign commit_val_o = {buf_q[BUF_W-HW-1:0], mem_rdata_i};

   a_r10_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
   a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   a_r10_index_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> (idx_q < cnt_q));
endmodule

// File: rtl/mmu_cmd_port.sv
module mmu_cmd_port
   import mmu_cmd_pkg::*;
#(
   parameter int AW   = 32,
   parameter int HW   = 16,
   parameter int TC_W = 32,
   parameter int RP_W = 64,
   parameter int SR_W = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cmd_valid_i,
   input  logic [CODE_W-1:0]   cmd_opword_i,
   input  logic [CODE_W-1:0]   cmd_ext_i,
   input  logic [AW-1:0]       cmd_base_i,
   output logic                busy_o,
   output logic                cls_vld_o,
   output logic [3:0]          cls_o,
   output logic                err_o,
   output logic                done_o,
   output logic                xlate_en_o,
   output logic                mem_req_o,
   output logic                mem_we_o,
   output logic [AW-1:0]       mem_addr_o,
   output logic [HW-1:0]       mem_wdata_o,
   input  logic [HW-1:0]       mem_rdata_i,
   input  logic                mem_ack_i
);
   localparam int CW     = $clog2(RP_W / HW + 1);
   localparam int TC_HWS = TC_W / HW;
   localparam int RP_HWS = RP_W / HW;
   localparam int SR_HWS = SR_W / HW;

   if (HW % 8 != 0 || TC_W % HW != 0 || RP_W % HW != 0 || SR_W % HW != 0) begin : g_bad_split
      $error("register widths must be whole numbers of byte-aligned halfwords");
   end
   if (TC_W > RP_W || SR_W > RP_W || RP_W < 2 * HW) begin : g_bad_buffer
      $error("root pointer width must cover every register and two halfwords");
   end

   cmd_dec_t        dec;
   logic            accept, start;
   logic [CW-1:0]   nhw;
   logic [RP_W-1:0] snap, commit_val;
   logic            commit;
   cmd_cls_e        cls_q;
   logic            cls_vld_q, err_q;
   mmu_tgt_e        tgt_q;

   mmu_cmd_classify i_classify (
      .opword_i (cmd_opword_i),
      .ext_i    (cmd_ext_i),
      .dec_o    (dec)
   );

   assign accept = cmd_valid_i && !busy_o;
   assign start  = accept && dec.move_ok;

   always_comb begin
      case (dec.tgt)
         TGT_CTRL:   nhw = CW'(TC_HWS);
         TGT_STATUS: nhw = CW'(SR_HWS);
         default:    nhw = CW'(RP_HWS);
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cls_q     <= CLS_NONE;
         cls_vld_q <= 1'b0;
         err_q     <= 1'b0;
         tgt_q     <= TGT_CTRL;
      end else begin
         cls_vld_q <= accept;
         err_q     <= accept && dec.move_bad;
         if (accept) cls_q <= dec.cls;
         if (start)  tgt_q <= dec.tgt;
      end
   end

   mmu_reg_bank #(.TC_W(TC_W), .RP_W(RP_W), .SR_W(SR_W)) i_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_tgt_i   (dec.tgt),
      .rd_val_o   (snap),
      .commit_i   (commit),
      .wr_tgt_i   (tgt_q),
      .wr_val_i   (commit_val),
      .xlate_en_o (xlate_en_o)
   );

   mmu_xfer_seq #(.AW(AW), .HW(HW), .BUF_W(RP_W)) i_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (start),
      .to_mem_i     (dec.to_mem),
      .nhw_i        (nhw),
      .base_i       (cmd_base_i),
      .snap_i       (snap),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .commit_o     (commit),
      .commit_val_o (commit_val),
      .mem_req_o    (mem_req_o),
      .mem_we_o     (mem_we_o),
      .mem_addr_o   (mem_addr_o),
      .mem_wdata_o  (mem_wdata_o),
      .mem_rdata_i  (mem_rdata_i),
      .mem_ack_i    (mem_ack_i)
   );

   assign cls_o     = cls_q;
   assign cls_vld_o = cls_vld_q;
   assign err_o     = err_q;

   a_r12_err_no_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> !busy_o);
   a_r14_busy_drops_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && cmd_valid_i) |=> !cls_vld_o);
   a_r9_xlate_only_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(xlate_en_o) |-> done_o);
   a_r12_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> cls_vld_o);
endmodule

// File: tb/test_mmu_cmd_port.sv
module test_mmu_cmd_port;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   typedef struct {
      logic [31:0] addr;
      logic        we;
      logic [15:0] data;
      string       tag;
   } xfer_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid;
   logic [15:0] cmd_op, cmd_ext;
   logic [31:0] cmd_base;
   logic        busy_o, cls_vld_o, err_o, done_o, xlate_en_o;
   logic [3:0]  cls_o;
   logic        mem_req_o, mem_we_o;
   logic [31:0] mem_addr_o;
   logic [15:0] mem_wdata_o;
   logic [15:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int    n_chk = 0, n_fail = 0, lat = 0, wcnt = 0;
   bit    finished = 0, saw_err = 0;
   xfer_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mmu_cmd_port i_mmu_cmd_port (
      .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid),
      .cmd_opword_i(cmd_op), .cmd_ext_i(cmd_ext), .cmd_base_i(cmd_base),
      .busy_o(busy_o), .cls_vld_o(cls_vld_o), .cls_o(cls_o), .err_o(err_o),
      .done_o(done_o), .xlate_en_o(xlate_en_o), .mem_req_o(mem_req_o),
      .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
   );

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
      end
   endtask

   task automatic push(input logic [31:0] a, input logic we, input logic [15:0] d, input string tag);
      xfer_t x;
      x.addr = a; x.we = we; x.data = d; x.tag = tag;
      exp_q.push_back(x);
   endtask

   // scoreboard monitor: memory model with programmable acknowledge latency
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         wcnt    = 0;
      end else if (mem_req_o) begin
         if (wcnt >= lat) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R12 unexpected transfer addr", mem_addr_o, 0);
               mem_rdata = '0;
            end else begin
               xfer_t x;
               x = exp_q.pop_front();
               chk(mem_addr_o == x.addr, {x.tag, " R10 halfword address"}, mem_addr_o, x.addr);
               chk(mem_we_o == x.we, {x.tag, " R8 direction"}, mem_we_o, x.we);
               if (x.we) chk(mem_wdata_o == x.data, {x.tag, " R4 write data"}, mem_wdata_o, x.data);
               mem_rdata = x.data;
            end
            mem_ack = 1'b1;
         end else begin
            wcnt++;
         end
      end
   end

   task automatic send(input logic [15:0] op, input logic [15:0] ext, input logic [31:0] base);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_ext = ext; cmd_base = base;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic check_cls(input logic [3:0] ecls, input bit eerr, input string r);
      chk(cls_vld_o == 1'b1, {r, " R3 class pulse"}, cls_vld_o, 1);
      chk(cls_o == ecls, {r, " class code"}, cls_o, ecls);
      chk(err_o == eerr, {r, " error flag"}, err_o, eerr);
   endtask

   task automatic wait_done(input string r);
      int n = 0;
      saw_err = 0;
      while (!done_o && n < 500) begin
         @(negedge clk);
         if (err_o) saw_err = 1;
         n++;
      end
      chk(done_o == 1'b1, {r, " R11 done seen"}, done_o, 1);
      chk(exp_q.size() == 0, {r, " R11 all halfwords moved before done"}, exp_q.size(), 0);
      chk(!saw_err, {r, " no error during move"}, saw_err, 0);
      @(negedge clk);
      chk(done_o == 1'b0, {r, " R11 done is one cycle"}, done_o, 0);
   endtask

   task automatic move(input logic [15:0] ext, input logic [31:0] base, input string r);
      send(16'hF000, ext, base);
      check_cls(4'd1, 1'b0, r);
      wait_done(r);
   endtask

   task automatic bad_move(input logic [15:0] ext, input string r);
      send(16'hF000, ext, 32'h0000_0700);
      check_cls(4'd1, 1'b1, r);
      chk(busy_o == 1'b0, {r, " no transfer started"}, busy_o, 0);
      @(negedge clk);
      chk(err_o == 1'b0, {r, " error is one cycle"}, err_o, 0);
      chk(mem_req_o == 1'b0, {r, " no request"}, mem_req_o, 0);
   endtask

   task automatic classify(input logic [15:0] op, input logic [15:0] ext, input logic [3:0] ecls, input string r);
      send(op, ext, 32'h0000_0800);
      check_cls(ecls, 1'b0, r);
      chk(busy_o == 1'b0, {r, " non-move stays idle"}, busy_o, 0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired R11 actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_ext = '0; cmd_base = '0;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(busy_o == 0 && mem_req_o == 0, "R13 idle after reset", {busy_o, mem_req_o}, 0);
      chk(cls_vld_o == 0 && err_o == 0 && done_o == 0, "R13 pulses low", {cls_vld_o, err_o, done_o}, 0);
      chk(xlate_en_o == 0, "R13 translation off", xlate_en_o, 0);
      rst_n = 1'b1;

      // R13 control word reads zero; R4 order
      lat = 0;
      push(32'h40, 1, 16'h0000, "R13"); push(32'h42, 1, 16'h0000, "R13");
      move(16'h0200, 32'h40, "R13");

      // R9 control load enables translation
      lat = 2;
      push(32'h100, 0, 16'h8000, "R9"); push(32'h102, 0, 16'h1234, "R9");
      move(16'h0000, 32'h100, "R9");
      chk(xlate_en_o == 1, "R9 enable from bit 31", xlate_en_o, 1);

      // R4 and R7: form 2 store of control word
      lat = 1;
      push(32'h200, 1, 16'h8000, "R4"); push(32'h202, 1, 16'h1234, "R4");
      move(16'h4200, 32'h200, "R7");

      // R5 supervisor root load, R7 form 2 CPU root load
      push(32'h1000, 0, 16'hA1B2, "R5"); push(32'h1002, 0, 16'hC3D4, "R5");
      push(32'h1004, 0, 16'h5566, "R5"); push(32'h1006, 0, 16'h7788, "R5");
      move(16'h0800, 32'h1000, "R5");
      push(32'h2000, 0, 16'h0102, "R7"); push(32'h2002, 0, 16'h0304, "R7");
      push(32'h2004, 0, 16'h0506, "R7"); push(32'h2006, 0, 16'h0708, "R7");
      move(16'h4C00, 32'h2000, "R7");

      // R8 readback of both roots: each load left the other intact
      lat = 3;
      push(32'h3000, 1, 16'hA1B2, "R8"); push(32'h3002, 1, 16'hC3D4, "R8");
      push(32'h3004, 1, 16'h5566, "R8"); push(32'h3006, 1, 16'h7788, "R8");
      move(16'h4A00, 32'h3000, "R8");
      push(32'h3100, 1, 16'h0102, "R8"); push(32'h3102, 1, 16'h0304, "R8");
      push(32'h3104, 1, 16'h0506, "R8"); push(32'h3106, 1, 16'h0708, "R8");
      move(16'h0E00, 32'h3100, "R8");

      // R6 status word
      lat = 0;
      push(32'h500, 0, 16'hBEEF, "R6");
      move(16'h6000, 32'h500, "R6");
      push(32'h502, 1, 16'hBEEF, "R6");
      move(16'h6200, 32'h502, "R6");

      // R12 unsupported codes and forms
      bad_move(16'h0400, "R12 reg code 1");
      bad_move(16'h1C00, "R12 reg code 7");
      bad_move(16'hE000, "R12 form 7");
      bad_move(16'hA001, "R12 form 5");
      push(32'h600, 1, 16'h8000, "R12"); push(32'h602, 1, 16'h1234, "R12");
      move(16'h0200, 32'h600, "R12 control unchanged");

      // R9 disable, enable holds until done
      lat = 2;
      push(32'h110, 0, 16'h0000, "R9"); push(32'h112, 0, 16'h00FF, "R9");
      send(16'hF000, 16'h0000, 32'h110);
      chk(xlate_en_o == 1, "R9 enable holds during move", xlate_en_o, 1);
      wait_done("R9");
      chk(xlate_en_o == 0, "R9 disable from bit 31", xlate_en_o, 0);

      // R1 operation word groups
      classify(16'hF045, 16'h0000, 4'd6, "R1 cond-set");
      classify(16'hF050, 16'h0000, 4'd6, "R1 cond-set upper");
      classify(16'hF04A, 16'h0000, 4'd9, "R1 dec-branch priority");
      classify(16'hF04F, 16'h0200, 4'd9, "R1 dec-branch top");
      classify(16'hF08C, 16'h0000, 4'd7, "R1 branch16");
      classify(16'hF0FF, 16'h0000, 4'd8, "R1 branch32");
      classify(16'hF100, 16'h0000, 4'd0, "R1 not mmu");
      classify(16'h4E71, 16'h0200, 4'd0, "R1 not mmu plain");

      // R2 extension priority
      classify(16'hF000, 16'h2010, 4'd2, "R2 load-entry");
      classify(16'hF000, 16'h2200, 4'd2, "R2 load-entry over flush");
      classify(16'hF000, 16'h2800, 4'd3, "R2 0x2800 is flush");
      classify(16'hF000, 16'h2C03, 4'd3, "R2 0x2C03 is flush");
      classify(16'hF000, 16'h3000, 4'd3, "R2 flush");
      classify(16'hF000, 16'hA000, 4'd4, "R2 flush-root");
      classify(16'hF000, 16'h8123, 4'd5, "R2 probe");

      // R14 command ignored while busy
      lat = 3;
      push(32'h4000, 0, 16'h1111, "R14"); push(32'h4002, 0, 16'h2222, "R14");
      push(32'h4004, 0, 16'h3333, "R14"); push(32'h4006, 0, 16'h4444, "R14");
      send(16'hF000, 16'h0800, 32'h4000);
      check_cls(4'd1, 1'b0, "R14 start");
      chk(busy_o == 1, "R14 busy", busy_o, 1);
      cmd_valid = 1'b1; cmd_op = 16'hF000; cmd_ext = 16'h1C00; cmd_base = 32'h0;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cls_vld_o == 0 && err_o == 0, "R14 no class or error while busy", {cls_vld_o, err_o}, 0);
      wait_done("R14");
      push(32'h4100, 1, 16'h1111, "R14"); push(32'h4102, 1, 16'h2222, "R14");
      push(32'h4104, 1, 16'h3333, "R14"); push(32'h4106, 1, 16'h4444, "R14");
      move(16'h0A00, 32'h4100, "R14 readback");

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule